// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single countdown timer on a simple word-addressed register bus. Each bus access is one cycle, with a write strobe, a read strobe, a word offset and 32-bit data. A clock-enable input supplies the raw tick rate. A prescaler divides that rate by 1, 16 or 256, and every prescaled tick moves the counter down by one. When the counter is already at zero, the next tick raises a sticky raw interrupt flag. What the counter does after that depends on the mode:

- **Periodic:** the counter restarts from a programmed reload value.
- **Free-running:** the counter restarts from the all-ones value of the selected width.
- **One-shot:** the counter parks at zero until software reloads it.

The interrupt output is the raw flag gated by an enable bit in the control register. The counter can be 16 or 32 bits wide. Software sets the reload value in one of two ways. The immediate load register also restarts the counter. The background load register changes only the value used at the next reload.

Top module: `ival_timer`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable only), the value register reads 0x0000FFFF, the raw status reads 0 and `irq` is low.
- R2: Word offsets decode as 0 load, 1 value, 2 control, 3 interrupt clear, 4 raw status, 5 masked status, 6 background load. Offsets 3 and 7 read as zero. Control bit 4 always reads 0. With `rd_en` low, `rdata` is zero.
- R3: A write to offset 0 stores the reload value and loads it into the counter on the same edge. In free-running mode the counter is instead loaded with all ones of the current width. Any prescaled tick in that cycle is dropped, and a parked one-shot counter is released.
- R4: A write to offset 6 changes only the reload value. The current count is untouched.
- R5: Writes to offsets 1, 4, 5 and 7 change no visible state.
- R6: Each prescaled tick decrements a nonzero count. A tick on a zero count sets the raw flag. In periodic mode (control bit 6) that tick also reloads the counter from the reload value.
- R7: Free-running mode (control bits 0 and 6 both clear) reloads the counter with 0xFFFF in 16-bit mode and 0xFFFFFFFF in 32-bit mode.
- R8: One-shot mode (control bit 0, which takes precedence over bit 6) sets the raw flag on the tick at zero. The counter then stays at zero and raises no further flags until offset 0 is written.
- R9: Only `tick_en` cycles with the enable bit (control bit 7) set advance the prescaler. Field bits 3:2 select the divide ratio: 00 and 11 divide by 1, 01 by 16, 10 by 256. A control write that changes this field restarts the divider, and a disabled timer holds the divider at zero.
- R10: In 16-bit mode (control bit 1 clear) the value and reload registers read back with bits 31:16 zero, and counting wraps within 16 bits. Values written in that mode keep only their low 16 bits.
- R11: `irq` equals the raw flag ANDed with the interrupt-enable bit (control bit 5). The masked status at offset 5 reads 0 whenever that bit is clear.
- R12: Any write to offset 3 clears the raw flag. If an expiry tick lands in the same cycle, the flag is set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Raw tick (clock enable) feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions can land on the same edge.

- **Expiry tick with interrupt clear.** The bench drives both on one edge, both in a directed case timed to the zero count and repeatedly under random traffic. The raw status must read 1 afterwards, and the counter must have reloaded.
- **Immediate load with a prescaled tick.** A load write with `tick_en` high must leave exactly the written value in the counter and raise no flag.

A reference model built from the requirements judges both collisions on every later read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int OFS_LOAD   = 0;
   localparam int OFS_VALUE  = 1;
   localparam int OFS_CTRL   = 2;
   localparam int OFS_ICLR   = 3;
   localparam int OFS_RAW    = 4;
   localparam int OFS_MSK    = 5;
   localparam int OFS_BGLOAD = 6;

   // Control byte, bit 7 down to bit 0.
   typedef struct packed {
      logic       run;       // 7: timer enable
      logic       periodic;  // 6: periodic reload
      logic       irq_en;    // 5: interrupt enable
      logic       spare;     // 4: reads zero
      logic [1:0] pre;       // 3:2 prescale select
      logic       wide;      // 1: 32-bit size
      logic       single;    // 0: one-shot
   } ctrl_t;

   localparam logic [7:0] CTRL_WMASK = 8'hEF;
   localparam ctrl_t      CTRL_RST   = ctrl_t'(8'h20);

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int DW = 32,
   parameter int NW = 16,
   parameter int AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] cnt_val,
   input  logic          expire,
   output ctrl_t         ctrl,
   output logic [DW-1:0] width_mask,
   output logic [DW-1:0] reload_val,
   output logic [DW-1:0] load_data,
   output logic          load_wr,
   output logic          pre_restart,
   output logic          raw,
   output logic [DW-1:0] rdata
);

   localparam logic [DW-1:0] NARROW_ONES = {DW{1'b1}} >> (DW - NW);

   ctrl_t         ctrl_q;
   logic [DW-1:0] reload_q;
   logic          raw_q;
   logic [DW-1:0] rd_mux;
   ctrl_t         ctrl_new;

   logic hit_load, hit_bg, hit_ctrl, hit_clr;
   assign hit_load = wr_en && (addr == AW'(OFS_LOAD));
   assign hit_bg   = wr_en && (addr == AW'(OFS_BGLOAD));
   assign hit_ctrl = wr_en && (addr == AW'(OFS_CTRL));
   assign hit_clr  = wr_en && (addr == AW'(OFS_ICLR));

   // Width mask variant: a narrow mode exists only when NW < DW.
   generate
      if (NW < DW) begin : g_narrow
         assign width_mask = ctrl_q.wide ? {DW{1'b1}} : NARROW_ONES;
      end else begin : g_full
         assign width_mask = {DW{1'b1}};
      end
   endgenerate

   assign ctrl_new    = ctrl_t'(wdata[7:0] & CTRL_WMASK);
   assign load_data   = wdata & width_mask;
   assign reload_val  = reload_q & width_mask;
   assign load_wr     = hit_load;
   assign pre_restart = hit_ctrl && (ctrl_new.pre != ctrl_q.pre);
   assign ctrl        = ctrl_q;
   assign raw         = raw_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= CTRL_RST;
         reload_q <= '0;
         raw_q    <= 1'b0;
      end else begin
         if (hit_ctrl)
            ctrl_q <= ctrl_new;
         if (hit_load || hit_bg)
            reload_q <= load_data;
         if (expire)
            raw_q <= 1'b1;
         else if (hit_clr)
            raw_q <= 1'b0;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (addr)
         AW'(OFS_LOAD), AW'(OFS_BGLOAD): rd_mux = reload_val;
         AW'(OFS_VALUE):                 rd_mux = cnt_val;
         AW'(OFS_CTRL):                  rd_mux = {{(DW-8){1'b0}}, ctrl_q};
         AW'(OFS_RAW):                   rd_mux = {{(DW-1){1'b0}}, raw_q};
         AW'(OFS_MSK):                   rd_mux = {{(DW-1){1'b0}}, raw_q & ctrl_q.irq_en};
         default:                        rd_mux = '0;
      endcase
   end

   assign rdata = rd_en ? rd_mux : '0;

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int SH1 = 4,
   parameter int SH2 = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       tick_en,
   input  logic       restart,
   input  logic [1:0] sel,
   output logic       pulse
);

   localparam int PW = SH2;
   localparam logic [PW-1:0] DIV1_M1 = PW'((64'd1 << SH1) - 64'd1);
   localparam logic [PW-1:0] DIV2_M1 = {PW{1'b1}};

   logic [PW-1:0] div_m1;
   logic [PW-1:0] cnt_q;

   always_comb begin
      case (sel)
         2'b01:   div_m1 = DIV1_M1;
         2'b10:   div_m1 = DIV2_M1;
         default: div_m1 = '0;
      endcase
   end

   assign pulse = run && tick_en && (cnt_q == div_m1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart || !run)
         cnt_q <= '0;
      else if (tick_en)
         cnt_q <= pulse ? '0 : cnt_q + 1'b1;
   end

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int DW = 32,
   parameter int NW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pulse,
   input  logic          single,
   input  logic          freerun,
   input  logic [DW-1:0] width_mask,
   input  logic [DW-1:0] reload_val,
   input  logic [DW-1:0] load_data,
   input  logic          load_wr,
   output logic [DW-1:0] cnt_val,
   output logic          expire,
   output logic          halted
);

   localparam logic [DW-1:0] NARROW_ONES = {DW{1'b1}} >> (DW - NW);

   logic [DW-1:0] cnt_q;
   logic          halt_q;
   logic [DW-1:0] cnt_eff;
   logic [DW-1:0] limit;
   logic          at_zero;
   logic          step;

   assign cnt_eff = cnt_q & width_mask;
   assign limit   = freerun ? width_mask : reload_val;
   assign at_zero = (cnt_eff == '0);
   assign step    = pulse && !halt_q && !load_wr;
   assign expire  = step && at_zero;
   assign cnt_val = cnt_eff;
   assign halted  = halt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= NARROW_ONES;
         halt_q <= 1'b0;
      end else if (load_wr) begin
         cnt_q  <= freerun ? width_mask : load_data;
         halt_q <= 1'b0;
      end else if (step) begin
         if (!at_zero)
            cnt_q <= cnt_eff - 1'b1;
         else if (single)
            halt_q <= 1'b1;
         else
            cnt_q <= limit;
      end
   end

endmodule

// File: rtl/ival_timer.sv
module ival_timer
   import tmr_pkg::*;
#(
   parameter int DW      = 32,
   parameter int NW      = 16,
   parameter int AW      = 3,
   parameter int PRE_SH1 = 4,
   parameter int PRE_SH2 = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          irq
);

   generate
      if (NW < 1 || NW > DW) begin : g_bad_nw
         $error("ival_timer: NW must lie in 1..DW");
      end
      if (DW < 8) begin : g_bad_dw
         $error("ival_timer: DW must hold the control byte");
      end
      if (AW < 3) begin : g_bad_aw
         $error("ival_timer: AW must cover seven offsets");
      end
      if (PRE_SH1 < 1 || PRE_SH1 >= PRE_SH2) begin : g_bad_pre
         $error("ival_timer: prescale shifts must satisfy 1 <= SH1 < SH2");
      end
   endgenerate

   ctrl_t         ctrl;
   logic [DW-1:0] width_mask;
   logic [DW-1:0] reload_val;
   logic [DW-1:0] load_data;
   logic          load_wr;
   logic          pre_restart;
   logic          raw;
   logic [DW-1:0] cnt_val;
   logic          expire;
   logic          halted;
   logic          pulse;
   logic          freerun;

   assign freerun = !ctrl.single && !ctrl.periodic;

   tmr_regs #(.DW(DW), .NW(NW), .AW(AW)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .rd_en       (rd_en),
      .addr        (addr),
      .wdata       (wdata),
      .cnt_val     (cnt_val),
      .expire      (expire),
      .ctrl        (ctrl),
      .width_mask  (width_mask),
      .reload_val  (reload_val),
      .load_data   (load_data),
      .load_wr     (load_wr),
      .pre_restart (pre_restart),
      .raw         (raw),
      .rdata       (rdata)
   );

   tmr_prescale #(.SH1(PRE_SH1), .SH2(PRE_SH2)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl.run),
      .tick_en (tick_en),
      .restart (pre_restart),
      .sel     (ctrl.pre),
      .pulse   (pulse)
   );

   tmr_count #(.DW(DW), .NW(NW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .pulse      (pulse),
      .single     (ctrl.single),
      .freerun    (freerun),
      .width_mask (width_mask),
      .reload_val (reload_val),
      .load_data  (load_data),
      .load_wr    (load_wr),
      .cnt_val    (cnt_val),
      .expire     (expire),
      .halted     (halted)
   );

   assign irq = raw && ctrl.irq_en;

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
   parameter int DW = 32,
   parameter int NW = 16,
   parameter int AW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          rd_en,
   input logic [AW-1:0] addr,
   input logic [DW-1:0] wdata,
   input logic [DW-1:0] rdata,
   input logic [7:0]    ctrl_bits,
   input logic          pulse,
   input logic          expire,
   input logic          halted,
   input logic          raw,
   input logic [DW-1:0] cnt_val
);

   localparam logic [DW-1:0] NARROW_ONES = {DW{1'b1}} >> (DW - NW);

   logic          wide, freerun;
   logic [DW-1:0] msk;
   assign wide    = ctrl_bits[1];
   assign freerun = !ctrl_bits[0] && !ctrl_bits[6];
   assign msk     = wide ? {DW{1'b1}} : NARROW_ONES;

   // R3
   load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == AW'(0) |=>
         cnt_val == ($past(freerun) ? $past(msk) : ($past(wdata) & $past(msk))));

   // R4
   bgload_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == AW'(6) && !pulse |=> $stable(cnt_val));

   // R5
   value_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == AW'(1) && !pulse |=> $stable(cnt_val));

   // R6
   expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> raw);

   // R7
   freerun_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire && freerun |=> cnt_val == $past(msk));

   // R8
   oneshot_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted && !(wr_en && (addr == AW'(0) || addr == AW'(2))) |=>
         halted && $stable(cnt_val) && !$past(expire));

   // R10
   narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr == AW'(1) && !wide |-> (rdata & ~NARROW_ONES) == '0);

   // R11
   masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr == AW'(5) && !ctrl_bits[5] |-> rdata == '0);

   // R12
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == AW'(3) && !expire |=> !raw);

endmodule

bind ival_timer tmr_chk #(.DW(DW), .NW(NW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .addr      (addr),
   .wdata     (wdata),
   .rdata     (rdata),
   .ctrl_bits (ctrl),
   .pulse     (pulse),
   .expire    (expire),
   .halted    (halted),
   .raw       (raw),
   .cnt_val   (cnt_val)
);

// File: tb/tb_ival_timer.sv
module tb_ival_timer;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick_en, wr_en, rd_en;
   logic [2:0]  addr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   ival_timer dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit reported = 0;

   // Reference model state.
   logic [7:0]  m_ctrl;
   logic [31:0] m_rel, m_cnt, last_rd;
   bit          m_raw, m_halt;
   int          m_pc;

   function automatic logic [31:0] wmask(logic [31:0] v, bit wide);
      return wide ? v : (v & 32'h0000FFFF);
   endfunction

   function automatic logic [31:0] m_read(int a);
      case (a)
         0, 6:    return wmask(m_rel, m_ctrl[1]);
         1:       return wmask(m_cnt, m_ctrl[1]);
         2:       return {24'd0, m_ctrl};
         4:       return {31'd0, m_raw};
         5:       return {31'd0, m_raw & m_ctrl[5]};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(int a);
      case (a)
         0:       return "R3";
         1:       return "R6";
         4:       return "R12";
         5:       return "R11";
         6:       return "R4";
         7:       return "R5";
         default: return "R2";
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_edge(bit w, int a, logic [31:0] d, bit t);
      bit wide, single, fr, run, pulse, ex;
      logic [31:0] ce, ones;
      int divm1;
      wide   = m_ctrl[1];
      single = m_ctrl[0];
      run    = m_ctrl[7];
      fr     = !single && !m_ctrl[6];
      ones   = wide ? 32'hFFFFFFFF : 32'h0000FFFF;
      divm1  = (m_ctrl[3:2] == 2'b01) ? 15 : (m_ctrl[3:2] == 2'b10) ? 255 : 0;
      pulse  = run && t && (m_pc == divm1);
      ce     = wmask(m_cnt, wide);
      ex     = 0;
      if (w && a == 0) begin
         m_cnt  = fr ? ones : wmask(d, wide);
         m_halt = 0;
      end else if (pulse && !m_halt) begin
         if (ce != 0) m_cnt = ce - 1;
         else begin
            ex = 1;
            if (single) m_halt = 1;
            else m_cnt = fr ? ones : wmask(m_rel, wide);
         end
      end
      if (w && a == 2 && d[3:2] != m_ctrl[3:2]) m_pc = 0;
      else if (!run) m_pc = 0;
      else if (t) m_pc = pulse ? 0 : m_pc + 1;
      if (ex) m_raw = 1;
      else if (w && a == 3) m_raw = 0;
      if (w && (a == 0 || a == 6)) m_rel = wmask(d, wide);
      if (w && a == 2) m_ctrl = d[7:0] & 8'hEF;
   endtask

   task automatic step(bit w, bit r, int a, logic [31:0] d, bit t);
      @(negedge clk);
      wr_en = w; rd_en = r; addr = 3'(a); wdata = d; tick_en = t;
      #1;
      check("R11", {31'd0, irq}, {31'd0, m_raw & m_ctrl[5]});
      last_rd = rdata;
      if (r) check(tag_of(a), rdata, m_read(a));
      else   check("R2", rdata, 32'd0);
      @(posedge clk);
      model_edge(w, a, d, t);
   endtask

   task automatic wr(int a, logic [31:0] d, bit t = 0);
      step(1, 0, a, d, t);
   endtask

   task automatic rd_exp(int a, logic [31:0] exp, string req);
      step(0, 1, a, 32'd0, 0);
      check(req, last_rd, exp);
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 32'd0, 1);
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 0; tick_en = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
      m_ctrl = 8'h20; m_rel = 0; m_cnt = 32'h0000FFFF; m_raw = 0; m_halt = 0; m_pc = 0;
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1 reset state
      rd_exp(2, 32'h20, "R1");
      rd_exp(1, 32'h0000FFFF, "R1");
      rd_exp(4, 32'h0, "R1");
      check("R1", {31'd0, irq}, 32'd0);
      rd_exp(7, 32'h0, "R2");

      // R10 narrow load, R3 free-run load gives all ones
      wr(0, 32'h00012345);
      rd_exp(0, 32'h00002345, "R10");
      rd_exp(1, 32'h0000FFFF, "R3");
      // R5 value register is read-only
      wr(1, 32'h0);
      wr(5, 32'h1);
      rd_exp(1, 32'h0000FFFF, "R5");

      // R7 free-run wrap: count down in periodic, then switch to free-run
      wr(2, 32'hE0);
      wr(0, 32'd2);
      ticks(2);
      rd_exp(1, 32'd0, "R6");
      wr(2, 32'hA0);
      ticks(1);
      rd_exp(1, 32'h0000FFFF, "R7");
      rd_exp(4, 32'd1, "R6");
      check("R11", {31'd0, irq}, 32'd1);
      // R11 masking
      wr(2, 32'h00);
      rd_exp(5, 32'd0, "R11");
      rd_exp(4, 32'd1, "R11");
      check("R11", {31'd0, irq}, 32'd0);
      wr(3, 32'hDEAD);
      rd_exp(4, 32'd0, "R12");

      // R12 collision of expiry and clear
      wr(2, 32'hE2);
      wr(0, 32'd2);
      ticks(2);
      wr(3, 32'h0, 1);
      rd_exp(4, 32'd1, "R12");
      rd_exp(1, 32'd2, "R6");
      // R3 load collides with a tick
      wr(0, 32'd5, 1);
      rd_exp(1, 32'd5, "R3");
      // R4 background load
      wr(0, 32'd2);
      wr(6, 32'd9);
      rd_exp(1, 32'd2, "R4");
      rd_exp(6, 32'd9, "R4");
      ticks(3);
      rd_exp(1, 32'd9, "R6");

      // R8 one-shot (bit 0 wins over bit 6)
      wr(2, 32'hE3);
      wr(3, 32'h0);
      wr(0, 32'd1);
      ticks(2);
      rd_exp(4, 32'd1, "R8");
      ticks(3);
      rd_exp(1, 32'd0, "R8");
      wr(3, 32'h0);
      ticks(2);
      rd_exp(4, 32'd0, "R8");
      wr(0, 32'd3);
      rd_exp(1, 32'd3, "R8");

      // R9 divide by 16
      wr(2, 32'hE6);
      wr(3, 32'h0);
      wr(0, 32'd1);
      ticks(31);
      rd_exp(4, 32'd0, "R9");
      ticks(1);
      rd_exp(4, 32'd1, "R9");
      rd_exp(1, 32'd1, "R9");

      // Constrained random traffic against the model
      for (int i = 0; i < 6000; i++) begin
         int r, a;
         logic [31:0] d;
         bit t;
         r = $urandom % 100;
         t = ($urandom % 10) < 7;
         d = $urandom;
         if (r < 6) begin
            d[7] = ($urandom % 8) != 0;
            case ($urandom % 12)
               0:       d[3:2] = 2'b01;
               1:       d[3:2] = 2'b11;
               2:       d[3:2] = 2'b10;
               default: d[3:2] = 2'b00;
            endcase
            step(1, 0, 2, d, t);
         end else if (r < 13) begin
            if (($urandom % 8) != 0) d = $urandom % 40;
            step(1, 0, 0, d, t);
         end else if (r < 17) begin
            if (($urandom % 8) != 0) d = $urandom % 40;
            step(1, 0, 6, d, t);
         end else if (r < 23) begin
            step(1, 0, 3, d, t);
         end else if (r < 27) begin
            a = ($urandom % 2) ? 1 : (($urandom % 2) ? 4 : (($urandom % 2) ? 5 : 7));
            step(1, 0, a, d, t);
         end else if (r < 60) begin
            step(0, 1, $urandom % 8, 32'd0, t);
         end else begin
            step(0, 0, 0, 32'd0, t);
         end
      end

      report();
      $finish;
   end

endmodule